// File: doc/BRIEF.md
# Subgrid pixel accumulator

This block builds the value of one image-domain subgrid pixel as a direct sum of phase-rotated visibilities. A subgrid covers a number of integration periods, and each period holds several frequency channels. Each channel arrives as one stream beat. A beat carries the pixel's phase index for its visibility, the subgrid phase offset, the channel wavenumber and a complex 2x2 visibility, which is four complex polarization samples.

For every beat the block forms a phase with one multiply-add. It sends that phase out to an attached phasor lookup and receives cosine and sine back one cycle later. It then rotates all four polarizations by that phasor in the same cycle, using sixteen real products, and adds the results into four complex accumulators. In total each channel costs seventeen multiply-adds and the pipeline never stalls. A clear input starts a new pixel. A one-cycle done pulse marks the moment the accumulators hold the complete sum for the beat flagged as last.

All arithmetic is signed fixed point. The phase is a 16-bit fraction of one turn (65536 = 2π), so it can drive the lookup without conversion. The phasor components are Q1.15. The accumulators are wide enough to hold 2048 full-scale terms exactly.

Top module: `subgrid_pixel_acc`

## Requirements
- R1: After reset, in_ready is 1, done is 0 and every accumulator field of pix reads 0.
- R2: In the cycle after a beat is accepted (in_valid and in_ready high, clear low), phase_o equals (in_offset − ((in_index × in_wavenum) arithmetically shifted right by 8)) modulo 2^16. in_index and in_wavenum are signed 16-bit values and in_offset is 16 bits, where 2^16 is one turn.
- R3: The block samples phasor_cos and phasor_sin exactly one cycle after it presents the matching phase_o, and uses them for that beat only.
- R4: For each polarization p, in_vis bits [32p+15:32p] hold the signed real part and bits [32p+31:32p+16] the signed imaginary part. Each accepted beat adds re·cos − im·sin to the real accumulator and re·sin + im·cos to the imaginary accumulator, at full precision, for all four polarizations at once.
- R5: Beats may arrive back to back, one per cycle. Every accepted beat since the last clear contributes exactly once.
- R6: done is a single-cycle pulse that appears four clock edges after the edge that accepted the beat with in_last set. At that point pix already holds the sum including that beat.
- R7: in_ready goes low in the cycle after the last beat is accepted. It stays low until the cycle in which done is high, and is high again in that cycle.
- R8: A clear cycle sets every accumulator to zero, discards all beats still in the pipeline as well as any beat presented in the same cycle, suppresses done for them, and leaves in_ready high.
- R9: Cycles with no accepted beat do not change pix once the pipeline has emptied.
- R10: pix field k (signed, 44 bits) sits at bits [44k+43:44k], with k = 2p for the real part and 2p+1 for the imaginary part of polarization p. A sum of 2048 full-scale terms is represented exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start a new pixel: zero sums, flush pipeline |
| in_valid | input | 1 | Beat present on the input stream |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_last | input | 1 | Beat is the final channel of the final visibility |
| in_index | input | 16 | Signed per-pixel phase index |
| in_wavenum | input | 16 | Signed channel wavenumber, 8 fraction bits |
| in_offset | input | 16 | Subgrid phase offset, one turn = 2^16 |
| in_vis | input | 128 | Four complex 16-bit polarization samples |
| phase_o | output | 16 | Phase sent to the phasor lookup |
| phasor_cos | input | 16 | Cosine of the phase, Q1.15, one cycle after phase_o |
| phasor_sin | input | 16 | Sine of the phase, Q1.15, one cycle after phase_o |
| done | output | 1 | Single-cycle pulse: pixel sum complete |
| pix | output | 352 | Eight signed 44-bit accumulator fields |

## Verification
A single beat exposes the phase arithmetic and the pairing of each rotated product with the correct accumulator half. A twelve-beat back-to-back burst with random visibilities and indices checks that no beat is lost or counted twice at full rate. Beats separated by idle gaps show that bubbles add nothing. A clear issued while terms are still in flight, together with a dropped beat, checks the flush. Finally, 2048 beats of the most negative sample against an extreme phasor drive the accumulators to their largest magnitude.

// File: rtl/spa_pkg.sv
package spa_pkg;

  // Control state of the input side.
  typedef enum logic {
    CTL_OPEN  = 1'b0,
    CTL_DRAIN = 1'b1
  } ctl_state_e;

  // Token that follows a beat down the pipeline.
  typedef struct packed {
    logic valid;
    logic last;
  } pipe_tag_t;

  // Accumulator width for a given product width and term count.
  function automatic int acc_bits(input int prod_w, input int terms);
    return prod_w + $clog2(terms);
  endfunction

endpackage

// File: rtl/spa_seq_ctrl.sv
module spa_seq_ctrl
  import spa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic accept,
  output logic s1_valid,
  output logic prod_valid,
  output logic term_valid,
  output logic done
);

  ctl_state_e st_q;
  pipe_tag_t  tag1_q, tag2_q, tag3_q;
  pipe_tag_t  tag_in;
  logic       done_q;
  logic       last_leaves;

  assign in_ready    = (st_q == CTL_OPEN);
  assign accept      = in_valid && in_ready && !clear;
  assign tag_in      = '{valid: accept, last: accept && in_last};
  assign last_leaves = tag3_q.valid && tag3_q.last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_OPEN;
      tag1_q <= '0;
      tag2_q <= '0;
      tag3_q <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      st_q   <= CTL_OPEN;
      tag1_q <= '0;
      tag2_q <= '0;
      tag3_q <= '0;
      done_q <= 1'b0;
    end else begin
      tag1_q <= tag_in;
      tag2_q <= tag1_q;
      tag3_q <= tag2_q;
      done_q <= last_leaves;
      if (accept && in_last) begin
        st_q <= CTL_DRAIN;
      end else if (last_leaves) begin
        st_q <= CTL_OPEN;
      end
    end
  end

  assign s1_valid   = tag1_q.valid;
  assign prod_valid = tag2_q.valid;
  assign term_valid = tag3_q.valid;
  assign done       = done_q;

endmodule

// File: rtl/spa_phase_unit.sv
module spa_phase_unit #(
  parameter int IDX_W   = 16,
  parameter int WN_W    = 16,
  parameter int PH_W    = 16,
  parameter int WN_FRAC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [IDX_W-1:0] index,
  input  logic [WN_W-1:0]  wavenum,
  input  logic [PH_W-1:0]  offset,
  output logic [PH_W-1:0]  phase
);

  localparam int MW = IDX_W + WN_W;

  // Single multiply-add: offset minus scaled index, wrapped to one turn.
  function automatic logic [PH_W-1:0] phase_mad(
    input logic [PH_W-1:0]  off,
    input logic [IDX_W-1:0] idx,
    input logic [WN_W-1:0]  wn
  );
    logic signed [MW-1:0] a, b, prod, scaled;
    a      = MW'($signed(idx));
    b      = MW'($signed(wn));
    prod   = a * b;
    scaled = prod >>> WN_FRAC;
    return off - scaled[PH_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (accept) begin
      phase <= phase_mad(offset, index, wavenum);
    end
  end

endmodule

// File: rtl/spa_cmac_lane.sv
module spa_cmac_lane #(
  parameter int VIS_W = 16,
  parameter int PHS_W = 16,
  parameter int ACC_W = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             s1_valid,
  input  logic             prod_valid,
  input  logic             term_valid,
  input  logic [VIS_W-1:0] vis_re,
  input  logic [VIS_W-1:0] vis_im,
  input  logic [PHS_W-1:0] cos_v,
  input  logic [PHS_W-1:0] sin_v,
  output logic [ACC_W-1:0] acc_re,
  output logic [ACC_W-1:0] acc_im
);

  localparam int PROD_W = VIS_W + PHS_W + 1;

  logic [VIS_W-1:0]         re1_q, im1_q, re2_q, im2_q;
  logic signed [PROD_W-1:0] pre_q, pim_q;
  logic signed [ACC_W-1:0]  sre_q, sim_q;

  // Real part of (a_re + j a_im)(c + j s): two real multiply-adds.
  function automatic logic signed [PROD_W-1:0] rot_real(
    input logic [VIS_W-1:0] a_re, input logic [VIS_W-1:0] a_im,
    input logic [PHS_W-1:0] c,    input logic [PHS_W-1:0] s
  );
    logic signed [PROD_W-1:0] ar, ai, cc, ss;
    ar = PROD_W'($signed(a_re));
    ai = PROD_W'($signed(a_im));
    cc = PROD_W'($signed(c));
    ss = PROD_W'($signed(s));
    return ar * cc - ai * ss;
  endfunction

  // Imaginary part: two more real multiply-adds.
  function automatic logic signed [PROD_W-1:0] rot_imag(
    input logic [VIS_W-1:0] a_re, input logic [VIS_W-1:0] a_im,
    input logic [PHS_W-1:0] c,    input logic [PHS_W-1:0] s
  );
    logic signed [PROD_W-1:0] ar, ai, cc, ss;
    ar = PROD_W'($signed(a_re));
    ai = PROD_W'($signed(a_im));
    cc = PROD_W'($signed(c));
    ss = PROD_W'($signed(s));
    return ar * ss + ai * cc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re1_q <= '0;
      im1_q <= '0;
      re2_q <= '0;
      im2_q <= '0;
      pre_q <= '0;
      pim_q <= '0;
    end else begin
      if (accept) begin
        re1_q <= vis_re;
        im1_q <= vis_im;
      end
      if (s1_valid) begin
        re2_q <= re1_q;
        im2_q <= im1_q;
      end
      if (prod_valid) begin
        pre_q <= rot_real(re2_q, im2_q, cos_v, sin_v);
        pim_q <= rot_imag(re2_q, im2_q, cos_v, sin_v);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sre_q <= '0;
      sim_q <= '0;
    end else if (clear) begin
      sre_q <= '0;
      sim_q <= '0;
    end else if (term_valid) begin
      sre_q <= sre_q + ACC_W'(pre_q);
      sim_q <= sim_q + ACC_W'(pim_q);
    end
  end

  assign acc_re = sre_q;
  assign acc_im = sim_q;

endmodule

// File: rtl/subgrid_pixel_acc.sv
module subgrid_pixel_acc #(
  parameter int NPOL      = 4,
  parameter int VIS_W     = 16,
  parameter int PHS_W     = 16,
  parameter int IDX_W     = 16,
  parameter int WN_W      = 16,
  parameter int PH_W      = 16,
  parameter int WN_FRAC   = 8,
  parameter int MAX_TERMS = 2048,
  localparam int ACC_W    = spa_pkg::acc_bits(VIS_W + PHS_W + 1, MAX_TERMS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_last,
  input  logic [IDX_W-1:0]        in_index,
  input  logic [WN_W-1:0]         in_wavenum,
  input  logic [PH_W-1:0]         in_offset,
  input  logic [NPOL*2*VIS_W-1:0] in_vis,
  output logic [PH_W-1:0]         phase_o,
  input  logic [PHS_W-1:0]        phasor_cos,
  input  logic [PHS_W-1:0]        phasor_sin,
  output logic                    done,
  output logic [NPOL*2*ACC_W-1:0] pix
);

  // Internal events brought out as named wires.
  logic accept;
  logic s1_valid;
  logic prod_valid;
  logic term_valid;

  spa_seq_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .accept     (accept),
    .s1_valid   (s1_valid),
    .prod_valid (prod_valid),
    .term_valid (term_valid),
    .done       (done)
  );

  spa_phase_unit #(
    .IDX_W   (IDX_W),
    .WN_W    (WN_W),
    .PH_W    (PH_W),
    .WN_FRAC (WN_FRAC)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .index   (in_index),
    .wavenum (in_wavenum),
    .offset  (in_offset),
    .phase   (phase_o)
  );

  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    spa_cmac_lane #(
      .VIS_W (VIS_W),
      .PHS_W (PHS_W),
      .ACC_W (ACC_W)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .accept     (accept),
      .s1_valid   (s1_valid),
      .prod_valid (prod_valid),
      .term_valid (term_valid),
      .vis_re     (in_vis[2*VIS_W*p +: VIS_W]),
      .vis_im     (in_vis[2*VIS_W*p + VIS_W +: VIS_W]),
      .cos_v      (phasor_cos),
      .sin_v      (phasor_sin),
      .acc_re     (pix[2*ACC_W*p +: ACC_W]),
      .acc_im     (pix[2*ACC_W*p + ACC_W +: ACC_W])
    );
  end

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int PIX_W = 352
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             term_valid,
  input logic             done,
  input logic [PIX_W-1:0] pix
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6

  AST_DONE_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(term_valid));  // R6

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);  // R7

  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !clear) |=> !in_ready);  // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pix == '0));  // R8

  AST_CLEAR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (in_ready && !done));  // R8

  AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_valid && !clear) |=> $stable(pix));  // R9

endmodule

bind subgrid_pixel_acc spa_checker #(.PIX_W(NPOL*2*ACC_W)) u_spa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .term_valid (term_valid),
  .done       (done),
  .pix        (pix)
);

// File: tb/tb_subgrid_pixel_acc.sv
`timescale 1ns/1ps
module tb_subgrid_pixel_acc;

  localparam int NPOL  = 4;
  localparam int ACC_W = 44;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_last = 1'b0;
  logic [15:0]  in_index = '0;
  logic [15:0]  in_wavenum = '0;
  logic [15:0]  in_offset = '0;
  logic [127:0] in_vis = '0;
  logic [15:0]  phase_o;
  logic [15:0]  phasor_cos = '0;
  logic [15:0]  phasor_sin = '0;
  logic         done;
  logic [NPOL*2*ACC_W-1:0] pix;

  int     vectors = 0;
  int     miscompares = 0;
  int     ph_mode = 0;
  int     lcg = 24680;
  longint exp_re[NPOL];
  longint exp_im[NPOL];

  always #2.5 clk = ~clk;

  subgrid_pixel_acc dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .in_index   (in_index),
    .in_wavenum (in_wavenum),
    .in_offset  (in_offset),
    .in_vis     (in_vis),
    .phase_o    (phase_o),
    .phasor_cos (phasor_cos),
    .phasor_sin (phasor_sin),
    .done       (done),
    .pix        (pix)
  );

  // Stand-in phasor lookup with one cycle of latency.
  function automatic logic [15:0] lk_cos(input logic [15:0] ph, input int mode);
    return (mode == 1) ? 16'h8000 : (ph ^ 16'h3C5A);
  endfunction
  function automatic logic [15:0] lk_sin(input logic [15:0] ph, input int mode);
    return (mode == 1) ? 16'h7FFF : {ph[7:0], ph[15:8]};
  endfunction

  always @(posedge clk) begin
    phasor_cos <= lk_cos(phase_o, ph_mode);
    phasor_sin <= lk_sin(phase_o, ph_mode);
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint field(input int k);
    logic signed [ACC_W-1:0] f;
    f = pix[k*ACC_W +: ACC_W];
    return longint'(f);
  endfunction

  function automatic logic [15:0] ref_phase(input int idx, input int wn, input int off);
    int scaled;
    scaled = (idx * wn) >>> 8;
    return 16'(off - scaled);
  endfunction

  task automatic model_add(input logic [15:0] ph, input logic [127:0] v);
    longint c, s, vr, vi;
    c = longint'($signed(lk_cos(ph, ph_mode)));
    s = longint'($signed(lk_sin(ph, ph_mode)));
    for (int p = 0; p < NPOL; p++) begin
      vr = longint'($signed(v[32*p +: 16]));
      vi = longint'($signed(v[32*p+16 +: 16]));
      exp_re[p] += vr * c - vi * s;
      exp_im[p] += vi * c + vr * s;
    end
  endtask

  task automatic model_zero();
    for (int p = 0; p < NPOL; p++) begin
      exp_re[p] = 0;
      exp_im[p] = 0;
    end
  endtask

  function automatic logic [127:0] rnd_vis();
    logic [127:0] v;
    for (int w = 0; w < 4; w++) begin
      lcg = lcg * 1103515245 + 12345;
      v[32*w +: 32] = lcg;
    end
    return v;
  endfunction

  function automatic int rnd16();
    lcg = lcg * 1103515245 + 12345;
    return int'($signed(lcg[23:8]));
  endfunction

  task automatic check_pix(input string req);
    for (int p = 0; p < NPOL; p++) begin
      chk(req, $sformatf("pol%0d real sum", p), field(2*p), exp_re[p]);
      chk(req, $sformatf("pol%0d imag sum", p), field(2*p+1), exp_im[p]);
    end
  endtask

  // Present one beat at a falling edge; returns one falling edge later.
  task automatic send(input int idx, input int wn, input int off,
                      input logic [127:0] v, input bit last);
    logic [15:0] ph;
    in_index   = 16'(idx);
    in_wavenum = 16'(wn);
    in_offset  = 16'(off);
    in_vis     = v;
    in_last    = last;
    in_valid   = 1'b1;
    chk("R5", "in_ready before beat", longint'(in_ready), 1);
    ph = ref_phase(idx, wn, off);
    model_add(ph, v);
    @(negedge clk);
    chk("R2", "phase_o", longint'(phase_o), longint'(ph));
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_zero();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called right after the last beat was sent.
  task automatic finish_pixel(input string req);
    int cnt;
    cnt = 1;
    while (done !== 1'b1 && cnt < 12) begin
      chk("R7", "in_ready while draining", longint'(in_ready), 0);
      @(negedge clk);
      cnt++;
    end
    chk("R6", "done latency in edges", cnt, 4);
    chk("R7", "in_ready in done cycle", longint'(in_ready), 1);
    check_pix(req);
    @(negedge clk);
    chk("R6", "done width", longint'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1", "in_ready after reset", longint'(in_ready), 1);
    chk("R1", "done after reset", longint'(done), 0);
    model_zero();
    check_pix("R1");
  endtask

  task automatic t_single();
    logic [127:0] v;
    pulse_clear();
    v = {16'sd1200, -16'sd700, -16'sd32768, 16'sd32767,
         16'sd5, -16'sd9, 16'sd20000, -16'sd15000};
    send(-1234, 517, 16'h4321, v, 1'b1);
    finish_pixel("R4");
    chk("R3", "pol0 real uses matched phasor", field(0), exp_re[0]);
  endtask

  task automatic t_burst();
    pulse_clear();
    for (int b = 0; b < 12; b++) begin
      send(rnd16(), rnd16(), rnd16(), rnd_vis(), b == 11);
    end
    finish_pixel("R5");
  endtask

  task automatic t_bubbles();
    logic [NPOL*2*ACC_W-1:0] snap;
    pulse_clear();
    for (int b = 0; b < 3; b++) begin
      send(rnd16(), rnd16(), rnd16(), rnd_vis(), 1'b0);
      idle(2);
    end
    idle(6);
    snap = pix;
    idle(5);
    chk("R9", "pix unchanged over idle cycles", longint'(pix == snap), 1);
    check_pix("R9");
    send(rnd16(), rnd16(), rnd16(), rnd_vis(), 1'b1);
    finish_pixel("R9");
  endtask

  task automatic t_clear_mid();
    pulse_clear();
    for (int b = 0; b < 5; b++) begin
      send(rnd16(), rnd16(), rnd16(), rnd_vis(), 1'b0);
    end
    in_vis   = rnd_vis();
    in_last  = 1'b1;
    in_valid = 1'b1;
    clear    = 1'b1;
    @(negedge clk);
    clear    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    model_zero();
    check_pix("R8");
    chk("R8", "in_ready after clear", longint'(in_ready), 1);
    for (int k = 0; k < 6; k++) begin
      chk("R8", "no done for discarded beats", longint'(done), 0);
      @(negedge clk);
    end
    check_pix("R8");
    send(rnd16(), rnd16(), rnd16(), rnd_vis(), 1'b0);
    send(rnd16(), rnd16(), rnd16(), rnd_vis(), 1'b1);
    finish_pixel("R8");
  endtask

  task automatic t_extreme();
    ph_mode = 1;
    pulse_clear();
    for (int b = 0; b < 2048; b++) begin
      send(0, 0, 0, {8{16'h8000}}, b == 2047);
    end
    finish_pixel("R10");
    chk("R10", "full-scale real sum", field(0), 64'sd4397979402240);
    chk("R10", "full-scale imag sum", field(7), 64'sd67108864);
    ph_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_single();
    t_burst();
    t_bubbles();
    t_clear_mid();
    t_extreme();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule